// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block is a bus master that turns a single request into a complete external bus cycle on a shared address/data bus. Each cycle covers a 20-bit address and a 16-bit data word. The low address bits and the data use the same pins. The top address bits are driven separately, and a latch-enable pulse lets external logic capture the address before the pins are reused for data.

A cycle is either a read or a write, aimed at either memory or I/O space. It runs through four clock states, T1 to T4. When the addressed device pulls its ready input low, wait states are inserted between T3 and T4. The block also drives the controls for external bus transceivers: a direction signal and an active-low enable. It returns read data together with a one-cycle completion pulse.

A request is accepted only while the controller is idle. The accepting clock edge is followed directly by T1.

Top module: `mux_bus_master`

## Requirements
- R1: Reset state. After reset and while idle: `busy`=0, `done`=0, `ale`=0, `rd_n`=1, `wr_n`=1, `den_n`=1, `dt_r`=1, `bhe_n`=1, `mio_o`=0, `bus_ad_oe`=0 and `upper_o`=0.
- R2: State order. A request sampled with `busy` low makes the next cycle T1, followed by T2 and T3. After T3 and any wait states comes T4, and after T4 the controller is idle again. `busy` is high from T1 through T4.
- R3: Address phase. In T1, and only in T1:
  - `ale` is high;
  - `bus_ad_oe`=1 and `bus_ad_o` carries address bits 15..0;
  - `upper_o` carries address bits 19..16.
- R4: Status phase. From T2 through T4, `upper_o` carries status instead of address. Bit 0 is the I/O flag, bit 1 is the write flag, and the remaining bits are 0.
- R5: Read cycle signals.
  - `dt_r`=0 from T1 to T4.
  - `rd_n`=0 and `den_n`=0 in T2, T3 and every wait state.
  - `bus_ad_oe`=0 from T2 on.
  - `wr_n` stays 1 for the whole cycle.
- R6: Write cycle signals.
  - `dt_r`=1 throughout the cycle.
  - In T2, T3 and every wait state: `bus_ad_oe`=1, `bus_ad_o` carries the write data, and `wr_n`=0 and `den_n`=0.
  - `rd_n` stays 1 for the whole cycle.
- R7: Space and byte selects. From T1 through T4, `mio_o` is 1 for memory and 0 for I/O, and `bhe_n` is the inverse of the request's high-byte flag.
- R8: Wait states. `ready` is sampled on the edge that ends T3 and on the edge that ends each wait state. A low sample inserts another wait state, and the first high sample leads to T4. With W wait states, `done` is high in the 5+W-th cycle after the accepting edge.
- R9: Turnaround. In T4, `den_n`=1, `bus_ad_oe`=0, `rd_n`=1 and `wr_n`=1.
- R10: Read data.
  - For a read, `bus_ad_i` is captured on the edge that moves the cycle into T4.
  - The captured value appears on `rdata` while `done` is high, which is for exactly one cycle, the cycle after T4.
  - `rdata` keeps its value through later write cycles.
- R11: A `req_valid` raised while `busy` is high is ignored. The running cycle is unaffected, and no new cycle starts after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a bus cycle (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_bhe | input | 1 | 1 = high byte lane takes part |
| req_addr | input | ADDR_W | Cycle address |
| req_wdata | input | DATA_W | Write data |
| ready | input | 1 | Device ready, sampled at end of T3 and wait states |
| bus_ad_i | input | DATA_W | Data read from the shared bus |
| bus_ad_o | output | DATA_W | Value driven on the shared bus |
| bus_ad_oe | output | 1 | Shared bus drive enable (0 = high impedance) |
| upper_o | output | ADDR_W-DATA_W | Upper address in T1, status afterwards |
| bhe_n | output | 1 | Active-low high-byte enable |
| ale | output | 1 | Address latch enable pulse |
| mio_o | output | 1 | 1 = memory, 0 = I/O |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| dt_r | output | 1 | Transceiver direction, 1 = transmit |
| den_n | output | 1 | Active-low transceiver enable |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Last captured read data |

## Verification
The bench sweeps every combination of read/write, memory/I/O, high-byte flag and 0 to 3 wait states. It compares every output in every state of each cycle with values derived from the state position.

During the cycles before the capture edge, the read bus carries the complement of the expected word. A controller that sampled one edge early or one edge late would therefore return the inverted word.

A design that miscounted wait states would shift `done` and would be caught in the T4 and wait-state checks. So would a design that left the bus driven or the transceiver enabled in T4.

Some cycles carry a stray request mid-cycle. A controller that queued that request would show `busy` or `ale` in the cycle after `done`.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_T1   = 3'd1,
      PH_T2   = 3'd2,
      PH_T3   = 3'd3,
      PH_TW   = 3'd4,
      PH_T4   = 3'd5
   } phase_e;

   typedef struct packed {
      logic write;
      logic io;
      logic bhe;
   } xfer_kind_t;

endpackage

// File: rtl/mbc_seq.sv
module mbc_seq
   import mbc_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  xfer_kind_t        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              ready,
   output phase_e            phase,
   output xfer_kind_t        kind_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              sample_now
);

   phase_e phase_nx;

   // The edge that leaves T3 or a wait state with ready high is the data edge.
   assign sample_now = ((phase == PH_T3) || (phase == PH_TW)) && ready;

   always_comb begin
      phase_nx = phase;
      unique case (phase)
         PH_IDLE: if (req_valid) phase_nx = PH_T1;
         PH_T1:   phase_nx = PH_T2;
         PH_T2:   phase_nx = PH_T3;
         PH_T3,
         PH_TW:   phase_nx = ready ? PH_T4 : PH_TW;
         PH_T4:   phase_nx = PH_IDLE;
         default: phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         kind_q  <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         phase <= phase_nx;
         if ((phase == PH_IDLE) && req_valid) begin
            kind_q  <= req_kind;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
      end
   end

endmodule

// File: rtl/mbc_drive.sv
module mbc_drive
   import mbc_pkg::*;
#(
   parameter int ADDR_W          = 20,
   parameter int DATA_W          = 16,
   parameter bit STATUS_ON_UPPER = 1'b1,
   localparam int UP_W           = ADDR_W - DATA_W
) (
   input  phase_e            phase,
   input  xfer_kind_t        kind_q,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] bus_ad_o,
   output logic              bus_ad_oe,
   output logic [UP_W-1:0]   upper_o,
   output logic              bhe_n,
   output logic              ale,
   output logic              mio_o,
   output logic              rd_n,
   output logic              wr_n,
   output logic              dt_r,
   output logic              den_n
);

   logic            in_t1;
   logic            strobe_win;
   logic            in_cycle;
   logic [UP_W-1:0] after_t1;

   assign in_t1      = (phase == PH_T1);
   assign strobe_win = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_TW);
   assign in_cycle   = (phase != PH_IDLE);

   // Selects what the upper lines carry once the address phase is over.
   generate
      if (STATUS_ON_UPPER) begin : g_status
         always_comb begin
            after_t1    = '0;
            after_t1[0] = kind_q.io;
            after_t1[1] = kind_q.write;
         end
      end else begin : g_hold_addr
         assign after_t1 = addr_q[ADDR_W-1:DATA_W];
      end
   endgenerate

   always_comb begin
      ale       = in_t1;
      bus_ad_oe = in_t1 || (kind_q.write && strobe_win);
      if (in_t1)
         bus_ad_o = addr_q[DATA_W-1:0];
      else if (kind_q.write && strobe_win)
         bus_ad_o = wdata_q;
      else
         bus_ad_o = '0;
      if (in_t1)
         upper_o = addr_q[ADDR_W-1:DATA_W];
      else if (in_cycle)
         upper_o = after_t1;
      else
         upper_o = '0;
      bhe_n = in_cycle ? ~kind_q.bhe : 1'b1;
      mio_o = in_cycle ? ~kind_q.io  : 1'b0;
      dt_r  = in_cycle ? kind_q.write : 1'b1;
      rd_n  = ~(strobe_win && !kind_q.write);
      wr_n  = ~(strobe_win &&  kind_q.write);
      den_n = ~strobe_win;
   end

endmodule

// File: rtl/mbc_capture.sv
module mbc_capture
   import mbc_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phase_e            phase,
   input  logic              sample_now,
   input  logic              is_write,
   input  logic [DATA_W-1:0] bus_ad_i,
   output logic [DATA_W-1:0] rdata,
   output logic              done
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
         done  <= 1'b0;
      end else begin
         done <= (phase == PH_T4);
         if (sample_now && !is_write)
            rdata <= bus_ad_i;
      end
   end

endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
   import mbc_pkg::*;
#(
   parameter int ADDR_W          = 20,
   parameter int DATA_W          = 16,
   parameter bit STATUS_ON_UPPER = 1'b1,
   localparam int UP_W           = ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_io,
   input  logic              req_bhe,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              ready,
   input  logic [DATA_W-1:0] bus_ad_i,
   output logic [DATA_W-1:0] bus_ad_o,
   output logic              bus_ad_oe,
   output logic [UP_W-1:0]   upper_o,
   output logic              bhe_n,
   output logic              ale,
   output logic              mio_o,
   output logic              rd_n,
   output logic              wr_n,
   output logic              dt_r,
   output logic              den_n,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata
);

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("mux_bus_master: DATA_W must be at least 2");
      end
      if (UP_W < 2) begin : g_bad_upper
         $error("mux_bus_master: ADDR_W must exceed DATA_W by at least 2");
      end
   endgenerate

   phase_e            phase;
   xfer_kind_t        req_kind;
   xfer_kind_t        kind_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              sample_now;

   assign req_kind = '{write: req_write, io: req_io, bhe: req_bhe};
   assign busy     = (phase != PH_IDLE);

   mbc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_kind   (req_kind),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .ready      (ready),
      .phase      (phase),
      .kind_q     (kind_q),
      .addr_q     (addr_q),
      .wdata_q    (wdata_q),
      .sample_now (sample_now)
   );

   mbc_drive #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATUS_ON_UPPER(STATUS_ON_UPPER)
   ) drive_i (
      .phase     (phase),
      .kind_q    (kind_q),
      .addr_q    (addr_q),
      .wdata_q   (wdata_q),
      .bus_ad_o  (bus_ad_o),
      .bus_ad_oe (bus_ad_oe),
      .upper_o   (upper_o),
      .bhe_n     (bhe_n),
      .ale       (ale),
      .mio_o     (mio_o),
      .rd_n      (rd_n),
      .wr_n      (wr_n),
      .dt_r      (dt_r),
      .den_n     (den_n)
   );

   mbc_capture #(.DATA_W(DATA_W)) cap_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase      (phase),
      .sample_now (sample_now),
      .is_write   (kind_q.write),
      .bus_ad_i   (bus_ad_i),
      .rdata      (rdata),
      .done       (done)
   );

endmodule

// File: rtl/mbc_chk.sv
module mbc_chk (
   input logic clk,
   input logic rst_n,
   input logic ale,
   input logic busy,
   input logic done,
   input logic rd_n,
   input logic wr_n,
   input logic dt_r,
   input logic den_n,
   input logic bus_ad_oe,
   input logic mio_o
);

   // R3
   ale_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);

   // R3
   ale_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (bus_ad_oe && busy));

   // R5
   read_receive_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> (!dt_r && !den_n && !bus_ad_oe && wr_n));

   // R6
   write_transmit_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> (dt_r && !den_n && bus_ad_oe && rd_n));

   // R7
   space_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ale) |-> $stable(mio_o));

   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2
   done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R9
   released_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_n && wr_n) |-> (den_n && !bus_ad_oe));

endmodule

bind mux_bus_master mbc_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .ale       (ale),
   .busy      (busy),
   .done      (done),
   .rd_n      (rd_n),
   .wr_n      (wr_n),
   .dt_r      (dt_r),
   .den_n     (den_n),
   .bus_ad_oe (bus_ad_oe),
   .mio_o     (mio_o)
);

// File: tb/mux_bus_master_tb_top.sv
module mux_bus_master_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 20;
   localparam int DATA_W     = 16;
   localparam int UP_W       = ADDR_W - DATA_W;

   // phase codes used by the bench model
   localparam int P_IDLE = 0;
   localparam int P_T1   = 1;
   localparam int P_T2   = 2;
   localparam int P_T3   = 3;
   localparam int P_TW   = 4;
   localparam int P_T4   = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic              req_io = 1'b0;
   logic              req_bhe = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic              ready = 1'b0;
   logic [DATA_W-1:0] bus_ad_i = '0;
   logic [DATA_W-1:0] bus_ad_o;
   logic              bus_ad_oe;
   logic [UP_W-1:0]   upper_o;
   logic              bhe_n, ale, mio_o, rd_n, wr_n, dt_r, den_n, busy, done;
   logic [DATA_W-1:0] rdata;

   int total = 0;
   int fails = 0;
   logic [DATA_W-1:0] last_rd = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mux_bus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_io(req_io), .req_bhe(req_bhe), .req_addr(req_addr),
      .req_wdata(req_wdata), .ready(ready), .bus_ad_i(bus_ad_i),
      .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe), .upper_o(upper_o),
      .bhe_n(bhe_n), .ale(ale), .mio_o(mio_o), .rd_n(rd_n), .wr_n(wr_n),
      .dt_r(dt_r), .den_n(den_n), .busy(busy), .done(done), .rdata(rdata)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Compare every output against the model for the given phase.
   task automatic chk_phase(input int ph, input bit wr, input bit io, input bit bhe,
                            input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd);
      bit mid = (ph == P_T2) || (ph == P_T3) || (ph == P_TW);
      bit act = (ph != P_IDLE);
      logic [UP_W-1:0] up_exp;
      chk("R2 busy", busy, act);
      chk("R3 ale", ale, ph == P_T1);
      chk("R5/R6/R9 bus_ad_oe", bus_ad_oe, (ph == P_T1) || (wr && mid));
      if (ph == P_T1) chk("R3 bus_ad_o address", bus_ad_o, a[DATA_W-1:0]);
      else if (wr && mid) chk("R6 bus_ad_o write data", bus_ad_o, wd);
      if (ph == P_T1) up_exp = a[ADDR_W-1:DATA_W];
      else if (act) up_exp = UP_W'({wr, io});
      else up_exp = '0;
      chk("R3/R4 upper_o", upper_o, up_exp);
      chk("R7 bhe_n", bhe_n, act ? !bhe : 1'b1);
      chk("R7 mio_o", mio_o, act ? !io : 1'b0);
      chk("R5/R6/R9 rd_n", rd_n, !(mid && !wr));
      chk("R5/R6/R9 wr_n", wr_n, !(mid && wr));
      chk("R5/R6 dt_r", dt_r, act ? wr : 1'b1);
      chk("R5/R6/R9 den_n", den_n, !mid);
   endtask

   task automatic run_cycle(input bit wr, input bit io, input bit bhe, input int waits,
                            input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                            input logic [DATA_W-1:0] rd, input bit stray);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_io = io; req_bhe = bhe;
      req_addr = a; req_wdata = wd; ready = 1'b0;
      @(negedge clk);
      chk_phase(P_T1, wr, io, bhe, a, wd);
      req_valid = 1'b0; req_addr = ~a; req_wdata = ~wd; req_write = !wr;
      bus_ad_i = ~rd;
      @(negedge clk);
      chk_phase(P_T2, wr, io, bhe, a, wd);
      // R11: a stray request while busy
      req_valid = stray;
      @(negedge clk);
      chk_phase(P_T3, wr, io, bhe, a, wd);
      req_valid = 1'b0;
      ready = (waits == 0);
      bus_ad_i = (waits == 0) ? rd : ~rd;
      for (int w = 0; w < waits; w++) begin
         @(negedge clk);
         chk_phase(P_TW, wr, io, bhe, a, wd); // R8 wait state held while ready low
         ready = (w == waits - 1);
         bus_ad_i = (w == waits - 1) ? rd : ~rd;
      end
      @(negedge clk);
      chk_phase(P_T4, wr, io, bhe, a, wd); // R9
      ready = 1'b0; bus_ad_i = ~rd;
      @(negedge clk);
      chk("R8 done after T4", done, 1'b1);
      if (!wr) last_rd = rd;
      chk("R10 rdata with done", rdata, last_rd);
      chk_phase(P_IDLE, wr, io, bhe, a, wd);
      @(negedge clk);
      chk("R10 done single cycle", done, 1'b0);
      chk("R11 no queued cycle busy", busy, 1'b0);
      chk("R11 no queued cycle ale", ale, 1'b0);
      chk("R10 rdata held", rdata, last_rd);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++; total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state (still in reset)
      chk_phase(P_IDLE, 1'b0, 1'b0, 1'b0, '0, '0);
      chk("R1 done", done, 1'b0);
      chk("R1 rdata", rdata, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_phase(P_IDLE, 1'b0, 1'b0, 1'b0, '0, '0);
      for (int k = 0; k < 32; k++) begin
         bit wr  = k[0];
         bit io  = k[1];
         bit bhe = k[2];
         int wt  = (k >> 3) & 3;
         logic [ADDR_W-1:0] a  = ADDR_W'(32'h5A3C1 * (k + 1) + k);
         logic [DATA_W-1:0] wd = DATA_W'(16'h1357 ^ (k * 16'h0F0F));
         logic [DATA_W-1:0] rd = DATA_W'(16'hA5C3 + k * 16'h0111);
         run_cycle(wr, io, bhe, wt, a, wd, rd, k[0] ^ k[3]);
      end
      // long wait run
      run_cycle(1'b0, 1'b0, 1'b1, 9, 20'hFFFFF, 16'h0, 16'hFFFF, 1'b1);
      run_cycle(1'b1, 1'b1, 1'b0, 0, 20'h00000, 16'hFFFF, 16'h0000, 1'b0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule